// File: doc/BRIEF.md
# Board Control Register Bank

A 32-bit register slave on a simple two-phase peripheral bus with a 4 KB address window. It holds a few board configuration words, a DLL lock-mask register, read-only identification words and a word whose low bits drive a bank of active-high LED outputs. Software addresses it with a setup phase followed by an access phase. The bank inserts one wait state, then completes the transfer with a single-cycle ready pulse. Read data and the error flag are registered and arrive together with that pulse.

The identification word is fixed at elaboration time. Its part-number field decides whether three optional configuration words exist. An access to a missing optional word, an unknown offset or a misaligned offset reads as zero and changes nothing. Such an access raises the error flag in the ready cycle. The four words at 0x0A0 to 0x0AC belong to an external configuration-channel sequencer. Accesses there are forwarded through a strobe port. A read there returns the value the sequencer presents.

Top module: `board_ctl_regs`

## Requirements
- R1: After reset, the words at 0x000, 0x004, 0x008, 0x014 and 0x018 read as zero, the DLL word at 0x100 reads 0xFFFF0001, all LED outputs are low and `pready` is low.
- R2: A transfer is taken on the first clock edge where `psel` and `penable` are high and `pready` is low. `pready` is high for exactly the one following cycle, and `prdata` and `accessError` are valid in that cycle; `pready` is low during the first access-phase cycle.
- R3: The words at 0x000 and 0x004 are fully writable and read back the last value written.
- R4: The part number is ID bits [15:4]. The words at 0x008 and 0x014 exist only when it equals 0x524 or 0x547, and the word at 0x018 exists only when it equals 0x524. An access to an absent one reads zero, leaves its value unchanged and sets `accessError`.
- R5: An access to an offset that is not listed in R3 to R9, including an offset whose bits [1:0] are non-zero, returns zero, changes no register and sets `accessError`.
- R6: The word at 0x00C always reads zero, and 0x010, 0xFF8 and 0xFFC read the parameter values `CFG4_VALUE`, `AID_VALUE` and `ID_VALUE`. A write to any of them changes nothing and leaves `accessError` low.
- R7: A write to 0x100 updates only bits [31:24] (the lock mask); bits [23:0] always read 0xFF0001.
- R8: LED output i equals bit i of the word at 0x004 from the cycle after each write to that word.
- R9: An access to 0x0A0, 0x0A4, 0x0A8 or 0x0AC raises `chanStrobe` in the ready cycle, with `chanWrite` equal to the direction, `chanIndex` equal to address bits [3:2] and, on writes, `chanWdata` equal to the written data. A read returns `chanRdata`, and `accessError` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase indicator |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address within the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Registered read data, valid with `pready` |
| pready | output | 1 | Transfer-complete pulse |
| accessError | output | 1 | Access hit an absent or unknown offset, valid with `pready` |
| leds | output | LED_COUNT | LED drive, active high |
| chanStrobe | output | 1 | One-cycle pulse for a configuration-channel access |
| chanWrite | output | 1 | Direction of the forwarded access |
| chanIndex | output | 2 | Word index within the channel window |
| chanWdata | output | 32 | Data of the forwarded write |
| chanRdata | input | 32 | Read value presented by the sequencer |

## Verification
The bench builds three copies of the bank whose part numbers are 0x524, 0x547 and 0x511. The same writes and reads go to the optional words of all three. A decode that compared the wrong field, or that treated the two optional groups alike, would show data on a copy that must return zero and an error flag. Other directed tests cover these cases:
- A DLL write with every bit set, to catch a design that lets the fixed lock bits be overwritten.
- A write to the read-only identification word, which must neither change it nor raise the error flag.
- A misaligned write aliasing the first word, which must be rejected rather than decoded by its upper bits.
- Writes and reads in the sequencer window, where a wrong index, direction or strobe timing appears directly on the channel port.

// File: rtl/board_ctl_pkg.sv
package board_ctl_pkg;

  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFF_CFG0 = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_CFG1 = 12'h004;
  localparam logic [ADDR_W-1:0] OFF_CFG2 = 12'h008;
  localparam logic [ADDR_W-1:0] OFF_CFG3 = 12'h00C;
  localparam logic [ADDR_W-1:0] OFF_CFG4 = 12'h010;
  localparam logic [ADDR_W-1:0] OFF_CFG5 = 12'h014;
  localparam logic [ADDR_W-1:0] OFF_CFG6 = 12'h018;
  localparam logic [ADDR_W-1:0] OFF_CHAN0 = 12'h0A0;
  localparam logic [ADDR_W-1:0] OFF_CHAN1 = 12'h0A4;
  localparam logic [ADDR_W-1:0] OFF_CHAN2 = 12'h0A8;
  localparam logic [ADDR_W-1:0] OFF_CHAN3 = 12'h0AC;
  localparam logic [ADDR_W-1:0] OFF_DLL  = 12'h100;
  localparam logic [ADDR_W-1:0] OFF_AID  = 12'hFF8;
  localparam logic [ADDR_W-1:0] OFF_ID   = 12'hFFC;

  // Fixed low part of the DLL word: all lock bits set, summary bit set.
  localparam logic [23:0] DLL_FIXED_LOW = 24'hFF0001;

  typedef enum logic [3:0] {
    TGT_CFG0, TGT_CFG1, TGT_CFG2, TGT_CFG3, TGT_CFG4, TGT_CFG5,
    TGT_CFG6, TGT_CHAN, TGT_DLL, TGT_AID, TGT_ID, TGT_NONE
  } target_e;

  // Strobes handed from the bus control to the register datapath.
  typedef struct packed {
    logic    take;
    logic    isWrite;
    target_e target;
    logic [1:0] chanIdx;
  } busStrobe_t;

endpackage

// File: rtl/board_ctl_ctrl.sv
module board_ctl_ctrl
  import board_ctl_pkg::*;
#(
  parameter logic [DATA_W-1:0] ID_VALUE = 32'h4104_5240
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  output busStrobe_t        strobe,
  output logic              pready,
  output logic              accessError
);

  localparam logic [11:0] PART_NUM   = ID_VALUE[15:4];
  localparam bit HAS_CFG2_CFG5 = (PART_NUM == 12'h524) || (PART_NUM == 12'h547);
  localparam bit HAS_CFG6      = (PART_NUM == 12'h524);

  target_e decodedTgt;
  logic    takeNow;
  logic    readyQ;
  logic    errQ;

  always_comb begin
    decodedTgt = TGT_NONE;
    case (paddr)
      OFF_CFG0:  decodedTgt = TGT_CFG0;
      OFF_CFG1:  decodedTgt = TGT_CFG1;
      OFF_CFG2:  decodedTgt = HAS_CFG2_CFG5 ? TGT_CFG2 : TGT_NONE;
      OFF_CFG3:  decodedTgt = TGT_CFG3;
      OFF_CFG4:  decodedTgt = TGT_CFG4;
      OFF_CFG5:  decodedTgt = HAS_CFG2_CFG5 ? TGT_CFG5 : TGT_NONE;
      OFF_CFG6:  decodedTgt = HAS_CFG6 ? TGT_CFG6 : TGT_NONE;
      OFF_CHAN0, OFF_CHAN1, OFF_CHAN2, OFF_CHAN3: decodedTgt = TGT_CHAN;
      OFF_DLL:   decodedTgt = TGT_DLL;
      OFF_AID:   decodedTgt = TGT_AID;
      OFF_ID:    decodedTgt = TGT_ID;
      default:   decodedTgt = TGT_NONE;
    endcase
  end

  assign takeNow = psel && penable && !readyQ;

  always_comb begin
    strobe.take    = takeNow;
    strobe.isWrite = pwrite;
    strobe.target  = decodedTgt;
    strobe.chanIdx = paddr[3:2];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      readyQ <= 1'b0;
      errQ   <= 1'b0;
    end else begin
      readyQ <= takeNow;
      errQ   <= takeNow && (decodedTgt == TGT_NONE);
    end
  end

  assign pready      = readyQ;
  assign accessError = errQ;

endmodule

// File: rtl/board_ctl_dp.sv
module board_ctl_dp
  import board_ctl_pkg::*;
#(
  parameter int                LED_COUNT  = 8,
  parameter logic [DATA_W-1:0] CFG4_VALUE = 32'h0,
  parameter logic [DATA_W-1:0] AID_VALUE  = 32'h0,
  parameter logic [DATA_W-1:0] ID_VALUE   = 32'h4104_5240
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  busStrobe_t           strobe,
  input  logic [DATA_W-1:0]    pwdata,
  input  logic [DATA_W-1:0]    chanRdata,
  output logic [DATA_W-1:0]    prdata,
  output logic [LED_COUNT-1:0] leds,
  output logic                 chanStrobe,
  output logic                 chanWrite,
  output logic [1:0]           chanIndex,
  output logic [DATA_W-1:0]    chanWdata
);

  localparam int MASK_W = DATA_W - 24;

  logic [DATA_W-1:0] cfg0Q, cfg1Q, cfg2Q, cfg5Q, cfg6Q;
  logic [MASK_W-1:0] dllMaskQ;
  logic [DATA_W-1:0] readMux;
  logic [DATA_W-1:0] prdataQ;
  logic              wrEn;

  assign wrEn = strobe.take && strobe.isWrite;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg0Q    <= '0;
      cfg1Q    <= '0;
      cfg2Q    <= '0;
      cfg5Q    <= '0;
      cfg6Q    <= '0;
      dllMaskQ <= '1;
    end else if (wrEn) begin
      case (strobe.target)
        TGT_CFG0: cfg0Q    <= pwdata;
        TGT_CFG1: cfg1Q    <= pwdata;
        TGT_CFG2: cfg2Q    <= pwdata;
        TGT_CFG5: cfg5Q    <= pwdata;
        TGT_CFG6: cfg6Q    <= pwdata;
        TGT_DLL:  dllMaskQ <= pwdata[DATA_W-1:24];
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (strobe.target)
      TGT_CFG0: readMux = cfg0Q;
      TGT_CFG1: readMux = cfg1Q;
      TGT_CFG2: readMux = cfg2Q;
      TGT_CFG4: readMux = CFG4_VALUE;
      TGT_CFG5: readMux = cfg5Q;
      TGT_CFG6: readMux = cfg6Q;
      TGT_CHAN: readMux = chanRdata;
      TGT_DLL:  readMux = {dllMaskQ, DLL_FIXED_LOW};
      TGT_AID:  readMux = AID_VALUE;
      TGT_ID:   readMux = ID_VALUE;
      default:  readMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prdataQ    <= '0;
      chanStrobe <= 1'b0;
      chanWrite  <= 1'b0;
      chanIndex  <= '0;
      chanWdata  <= '0;
    end else begin
      chanStrobe <= strobe.take && (strobe.target == TGT_CHAN);
      if (strobe.take) begin
        prdataQ <= strobe.isWrite ? '0 : readMux;
        if (strobe.target == TGT_CHAN) begin
          chanWrite <= strobe.isWrite;
          chanIndex <= strobe.chanIdx;
          if (strobe.isWrite) chanWdata <= pwdata;
        end
      end
    end
  end

  assign prdata = prdataQ;

  for (genvar i = 0; i < LED_COUNT; i++) begin : g_led
    assign leds[i] = cfg1Q[i];
  end

endmodule

// File: rtl/board_ctl_regs.sv
module board_ctl_regs
  import board_ctl_pkg::*;
#(
  parameter int                LED_COUNT  = 8,
  parameter logic [DATA_W-1:0] CFG4_VALUE = 32'h0000_0003,
  parameter logic [DATA_W-1:0] AID_VALUE  = 32'h0200_0008,
  parameter logic [DATA_W-1:0] ID_VALUE   = 32'h4104_5240
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 psel,
  input  logic                 penable,
  input  logic                 pwrite,
  input  logic [ADDR_W-1:0]    paddr,
  input  logic [DATA_W-1:0]    pwdata,
  output logic [DATA_W-1:0]    prdata,
  output logic                 pready,
  output logic                 accessError,
  output logic [LED_COUNT-1:0] leds,
  output logic                 chanStrobe,
  output logic                 chanWrite,
  output logic [1:0]           chanIndex,
  output logic [DATA_W-1:0]    chanWdata,
  input  logic [DATA_W-1:0]    chanRdata
);

  busStrobe_t strobe;

  board_ctl_ctrl #(.ID_VALUE(ID_VALUE)) u_ctrl (
    .clk(clk), .rstN(rstN), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .strobe(strobe),
    .pready(pready), .accessError(accessError)
  );

  board_ctl_dp #(
    .LED_COUNT(LED_COUNT), .CFG4_VALUE(CFG4_VALUE),
    .AID_VALUE(AID_VALUE), .ID_VALUE(ID_VALUE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pwdata(pwdata),
    .chanRdata(chanRdata), .prdata(prdata), .leds(leds),
    .chanStrobe(chanStrobe), .chanWrite(chanWrite),
    .chanIndex(chanIndex), .chanWdata(chanWdata)
  );

endmodule

// File: rtl/board_ctl_checker.sv
module board_ctl_checker #(
  parameter int LED_COUNT = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 pwrite,
  input logic [11:0]          paddr,
  input logic [31:0]          pwdata,
  input logic [31:0]          prdata,
  input logic                 pready,
  input logic                 accessError,
  input logic [LED_COUNT-1:0] leds,
  input logic                 chanStrobe
);

  assert_ready_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    pready |=> !pready);

  assert_err_only_ready_R2: assert property (@(posedge clk) disable iff (!rstN)
    accessError |-> pready);

  assert_err_reads_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    pready && accessError |-> prdata == 32'h0);

  assert_ro_no_err_R6: assert property (@(posedge clk) disable iff (!rstN)
    pready && ($past(paddr) == 12'hFFC || $past(paddr) == 12'hFF8) |-> !accessError);

  assert_dll_low_fixed_R7: assert property (@(posedge clk) disable iff (!rstN)
    pready && !$past(pwrite) && $past(paddr) == 12'h100 |-> prdata[23:0] == 24'hFF0001);

  assert_led_follow_R8: assert property (@(posedge clk) disable iff (!rstN)
    pready && $past(pwrite) && $past(paddr) == 12'h004
      |-> leds == $past(pwdata[LED_COUNT-1:0]));

  assert_chan_strobe_R9: assert property (@(posedge clk) disable iff (!rstN)
    chanStrobe |-> pready && !accessError);

endmodule

bind board_ctl_regs board_ctl_checker #(.LED_COUNT(LED_COUNT)) u_checker (
  .clk(clk), .rstN(rstN), .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
  .prdata(prdata), .pready(pready), .accessError(accessError),
  .leds(leds), .chanStrobe(chanStrobe)
);

// File: tb/board_ctl_regs_bench.sv
module board_ctl_regs_bench;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] CFG4_V = 32'h0000_0003;
  localparam logic [31:0] AID_V  = 32'h0200_0008;
  localparam logic [31:0] ID_A   = 32'h4104_5240; // part 0x524
  localparam logic [31:0] ID_B   = 32'h4104_5470; // part 0x547
  localparam logic [31:0] ID_C   = 32'h4104_5110; // part 0x511
  localparam logic [31:0] CHAN_RD = 32'h1234_ABCD;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] chanRdata = CHAN_RD;

  logic [31:0] rdA, rdB, rdC;
  logic readyA, readyB, readyC, errA, errB, errC;
  logic [7:0] ledsA, ledsB, ledsC;
  logic chStrA, chStrB, chStrC, chWrA, chWrB, chWrC;
  logic [1:0] chIdxA, chIdxB, chIdxC;
  logic [31:0] chWdA, chWdB, chWdC;

  int checks = 0;
  int fails = 0;

  logic [31:0] lastRd [3];
  logic        lastErr [3];
  logic        earlyReady, lateReady;
  logic        lastChStr, lastChWr;
  logic [1:0]  lastChIdx;
  logic [31:0] lastChWd;

  always #(CLK_PERIOD/2) clk = ~clk;

  board_ctl_regs #(.LED_COUNT(8), .CFG4_VALUE(CFG4_V), .AID_VALUE(AID_V), .ID_VALUE(ID_A)) u_board_ctl_regs (
    .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(rdA), .pready(readyA), .accessError(errA),
    .leds(ledsA), .chanStrobe(chStrA), .chanWrite(chWrA), .chanIndex(chIdxA),
    .chanWdata(chWdA), .chanRdata(chanRdata));

  board_ctl_regs #(.LED_COUNT(8), .CFG4_VALUE(CFG4_V), .AID_VALUE(AID_V), .ID_VALUE(ID_B)) u_board_ctl_regs_547 (
    .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(rdB), .pready(readyB), .accessError(errB),
    .leds(ledsB), .chanStrobe(chStrB), .chanWrite(chWrB), .chanIndex(chIdxB),
    .chanWdata(chWdB), .chanRdata(chanRdata));

  board_ctl_regs #(.LED_COUNT(8), .CFG4_VALUE(CFG4_V), .AID_VALUE(AID_V), .ID_VALUE(ID_C)) u_board_ctl_regs_511 (
    .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(rdC), .pready(readyC), .accessError(errC),
    .leds(ledsC), .chanStrobe(chStrC), .chanWrite(chWrC), .chanIndex(chIdxC),
    .chanWdata(chWdC), .chanRdata(chanRdata));

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [11:0] addr, input logic wr, input logic [31:0] data);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = addr; pwdata = data;
    @(negedge clk);
    penable = 1'b1;
    #1 earlyReady = readyA;
    @(negedge clk);
    lateReady = readyA;
    lastRd[0] = rdA; lastRd[1] = rdB; lastRd[2] = rdC;
    lastErr[0] = errA; lastErr[1] = errB; lastErr[2] = errC;
    lastChStr = chStrA; lastChWr = chWrA; lastChIdx = chIdxA; lastChWd = chWdA;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic expectRead(input logic [11:0] addr, input int inst, input logic [31:0] exp,
                            input logic expErr, input string tag);
    xfer(addr, 1'b0, 32'h0);
    check(lastRd[inst] == exp, tag, lastRd[inst], exp);
    check(lastErr[inst] == expErr, {tag, " err"}, 32'(lastErr[inst]), 32'(expErr));
  endtask

  task automatic testReset();
    check(ledsA == 8'h00, "R1 leds", 32'(ledsA), 0);
    check(readyA == 1'b0, "R1 pready", 32'(readyA), 0);
    expectRead(12'h000, 0, 32'h0, 1'b0, "R1 cfg0");
    expectRead(12'h004, 0, 32'h0, 1'b0, "R1 cfg1");
    expectRead(12'h008, 0, 32'h0, 1'b0, "R1 cfg2");
    expectRead(12'h014, 0, 32'h0, 1'b0, "R1 cfg5");
    expectRead(12'h018, 0, 32'h0, 1'b0, "R1 cfg6");
    expectRead(12'h100, 0, 32'hFFFF_0001, 1'b0, "R1 dll");
  endtask

  task automatic testTiming();
    xfer(12'hFFC, 1'b0, 32'h0);
    check(earlyReady == 1'b0, "R2 wait state", 32'(earlyReady), 0);
    check(lateReady == 1'b1, "R2 ready pulse", 32'(lateReady), 1);
    check(lastRd[0] == ID_A, "R2 data with ready", lastRd[0], ID_A);
    @(negedge clk);
    check(readyA == 1'b0, "R2 ready drops", 32'(readyA), 0);
  endtask

  task automatic testCfgRw();
    xfer(12'h000, 1'b1, 32'hDEAD_BEEF);
    check(lastErr[0] == 1'b0, "R3 cfg0 write err", 32'(lastErr[0]), 0);
    expectRead(12'h000, 0, 32'hDEAD_BEEF, 1'b0, "R3 cfg0 readback");
    xfer(12'h004, 1'b1, 32'h5A5A_5AA5);
    check(ledsA == 8'hA5, "R8 leds after write", 32'(ledsA), 32'hA5);
    expectRead(12'h004, 0, 32'h5A5A_5AA5, 1'b0, "R3 cfg1 readback");
    xfer(12'h004, 1'b1, 32'h0000_0081);
    check(ledsA == 8'h81, "R8 leds second pattern", 32'(ledsA), 32'h81);
  endtask

  task automatic testOptional();
    xfer(12'h008, 1'b1, 32'h0000_0011);
    check(lastErr[0] == 1'b0, "R4 cfg2 write 524", 32'(lastErr[0]), 0);
    check(lastErr[1] == 1'b0, "R4 cfg2 write 547", 32'(lastErr[1]), 0);
    check(lastErr[2] == 1'b1, "R4 cfg2 write 511", 32'(lastErr[2]), 1);
    xfer(12'h014, 1'b1, 32'h0000_0055);
    xfer(12'h018, 1'b1, 32'h0000_0066);
    check(lastErr[0] == 1'b0, "R4 cfg6 write 524", 32'(lastErr[0]), 0);
    check(lastErr[1] == 1'b1, "R4 cfg6 write 547", 32'(lastErr[1]), 1);
    expectRead(12'h008, 0, 32'h11, 1'b0, "R4 cfg2 on 524");
    expectRead(12'h008, 1, 32'h11, 1'b0, "R4 cfg2 on 547");
    expectRead(12'h008, 2, 32'h0, 1'b1, "R4 cfg2 on 511");
    expectRead(12'h014, 0, 32'h55, 1'b0, "R4 cfg5 on 524");
    expectRead(12'h014, 1, 32'h55, 1'b0, "R4 cfg5 on 547");
    expectRead(12'h014, 2, 32'h0, 1'b1, "R4 cfg5 on 511");
    expectRead(12'h018, 0, 32'h66, 1'b0, "R4 cfg6 on 524");
    expectRead(12'h018, 1, 32'h0, 1'b1, "R4 cfg6 on 547");
    expectRead(12'h018, 2, 32'h0, 1'b1, "R4 cfg6 on 511");
  endtask

  task automatic testUnknown();
    xfer(12'h200, 1'b1, 32'hFFFF_FFFF);
    check(lastErr[0] == 1'b1, "R5 unknown write err", 32'(lastErr[0]), 1);
    expectRead(12'h200, 0, 32'h0, 1'b1, "R5 unknown read");
    xfer(12'h001, 1'b1, 32'h1111_2222);
    check(lastErr[0] == 1'b1, "R5 misaligned write err", 32'(lastErr[0]), 1);
    expectRead(12'h000, 0, 32'hDEAD_BEEF, 1'b0, "R5 cfg0 untouched");
    expectRead(12'h0B0, 0, 32'h0, 1'b1, "R5 past channel window");
  endtask

  task automatic testReadOnly();
    expectRead(12'h00C, 0, 32'h0, 1'b0, "R6 cfg3");
    expectRead(12'h010, 0, CFG4_V, 1'b0, "R6 cfg4");
    expectRead(12'hFF8, 0, AID_V, 1'b0, "R6 aid");
    xfer(12'hFFC, 1'b1, 32'h0);
    check(lastErr[0] == 1'b0, "R6 id write no err", 32'(lastErr[0]), 0);
    xfer(12'h010, 1'b1, 32'hFFFF_FFFF);
    check(lastErr[0] == 1'b0, "R6 cfg4 write no err", 32'(lastErr[0]), 0);
    expectRead(12'hFFC, 0, ID_A, 1'b0, "R6 id unchanged");
    expectRead(12'h010, 0, CFG4_V, 1'b0, "R6 cfg4 unchanged");
  endtask

  task automatic testDll();
    xfer(12'h100, 1'b1, 32'h1234_5678);
    expectRead(12'h100, 0, 32'h12FF_0001, 1'b0, "R7 dll mask only");
    xfer(12'h100, 1'b1, 32'h0000_0000);
    expectRead(12'h100, 0, 32'h00FF_0001, 1'b0, "R7 dll low bits kept");
  endtask

  task automatic testChannel();
    xfer(12'h0A8, 1'b1, 32'hCAFE_F00D);
    check(lastChStr == 1'b1, "R9 strobe on write", 32'(lastChStr), 1);
    check(lastChWr == 1'b1, "R9 write dir", 32'(lastChWr), 1);
    check(lastChIdx == 2'd2, "R9 write index", 32'(lastChIdx), 2);
    check(lastChWd == 32'hCAFE_F00D, "R9 write data", lastChWd, 32'hCAFE_F00D);
    check(lastErr[0] == 1'b0, "R9 write no err", 32'(lastErr[0]), 0);
    xfer(12'h0A4, 1'b0, 32'h0);
    check(lastChStr == 1'b1, "R9 strobe on read", 32'(lastChStr), 1);
    check(lastChWr == 1'b0, "R9 read dir", 32'(lastChWr), 0);
    check(lastChIdx == 2'd1, "R9 read index", 32'(lastChIdx), 1);
    check(lastRd[0] == CHAN_RD, "R9 read data", lastRd[0], CHAN_RD);
    check(lastErr[0] == 1'b0, "R9 read no err", 32'(lastErr[0]), 0);
    @(negedge clk);
    check(chStrA == 1'b0, "R9 strobe single cycle", 32'(chStrA), 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testTiming();
    testCfgRw();
    testOptional();
    testUnknown();
    testReadOnly();
    testDll();
    testChannel();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule